// File: doc/BRIEF.md
# Serial ADC Control-Byte Front End

This block is the device-side serial interface of a multichannel successive-approximation converter. A host drives an active-low chip select, a serial clock and a serial data line. The block runs on a faster system clock, brings the three pins into that domain, and watches the serial clock for edges. It skips leading zeros, takes the first one as a start bit and assembles an eight-bit control byte. It then decodes from that byte the channel selection, the input polarity, the input mode and the power/clock mode.

The block times the track phase and the hold instant for the analog core. At hold it takes a result word from the core and starts a conversion. While the conversion runs it shifts that word out, most significant bit first, on falling serial-clock edges. It also tracks whether a conversion is still running, so that a new start bit is accepted only when it is allowed. A new start bit is allowed when the converter is idle, once result bit 3 has been shifted out, or after chip select has been toggled. The last case terminates the running conversion.

All conversion steps advance on serial-clock falling edges, whichever clock mode the byte selects. The mode is only decoded and presented to the rest of the chip.

Top module: `adc_serial_frontend`

## Requirements
- R1: While csN is high, serial-clock edges and data have no effect: no byte is assembled, trackOn and convActive stay low, and no sampleStb occurs.
- R2: With csN low, data is taken on each serial-clock rising edge. Any number of leading zeros is ignored, and the first one taken is the start bit, which becomes bit 7 of the control byte.
- R3: The control byte, MSB first, is start, channel code c2 c1 c0, unipolar flag (1 = unipolar), single-ended flag (1 = single-ended), and mode bits m1 m0. At hold, unipolar, singleEnded and pwrMode={m1,m0} take these values. pwrMode codes are 0 full power-down, 1 fast power-down, 2 internal clock, 3 external clock.
- R4: In single-ended mode, codes c2c1c0 = 000,100,001,101,010,110,011,111 give posCh = 0,1,2,3,4,5,6,7. negIsCom is 1 and negCh reads 0.
- R5: In differential mode, codes 000,001,010,011 give the pairs posCh/negCh = 0/1, 2/3, 4/5, 6/7, and codes 100..111 give the same pairs reversed. negIsCom is 0.
- R6: trackOn rises on the serial-clock falling edge after the fifth control bit. On the falling edge after the eighth bit, trackOn falls, sampleStb pulses high for exactly one system clock and convActive rises.
- R7: sdo is 0 before the first conversion. On the 1st to 10th falling edges after hold it shows resultWord bits 9 down to 0, and 0 after that. convActive clears on the 12th falling edge after hold.
- R8: During a conversion, a one taken before the 7th falling edge after hold (the edge that drives result bit 3) is ignored. A one taken after that edge starts a new byte, and the running conversion keeps shifting out its remaining bits.
- R9: A rise of csN drops a partly received byte: trackOn clears, and no hold follows from the dropped bits.
- R10: After csN has been toggled during a conversion, the next one taken is a start bit. It terminates the running conversion: convActive goes to 0 and sdo to 0.
- R11: sdoOe is 0 while csN is high and 1 while it is low. Every output reflects a pin change on the third system-clock edge after the change.
- R12: After reset, sdoOe, sdo, trackOn, sampleStb, convActive, posCh, negCh, unipolar and pwrMode are 0, and negIsCom and singleEnded are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| resultWord | input | RES_W | Conversion result from the analog core, taken at hold |
| sdo | output | 1 | Serial data to the host |
| sdoOe | output | 1 | Output enable for sdo (0 = high impedance) |
| posCh | output | 3 | Positive input channel index |
| negCh | output | 3 | Negative input channel index (differential mode) |
| negIsCom | output | 1 | Negative input is the common ground reference |
| unipolar | output | 1 | Unipolar (1) or bipolar (0) conversion |
| singleEnded | output | 1 | Single-ended (1) or differential (0) input |
| pwrMode | output | 2 | Power/clock mode code |
| trackOn | output | 1 | Track phase active |
| sampleStb | output | 1 | One-cycle hold strobe; the conversion starts here |
| convActive | output | 1 | A conversion is in progress |

## Verification
Every pin change reaches the outputs on the third system-clock edge after it. Two of those edges come from the synchroniser and one from the state register. The bench drives pins just after a falling system-clock edge and holds back its comparison for the next two falling edges. From the third falling edge on, it compares all outputs with its model on every clock until the next drive. The sampleStb pulse is expected only in that first compared cycle and low in every other cycle, so a strobe that is one cycle early, late or too long is caught.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  localparam int CTRL_W   = 8;
  localparam int CH_W     = 3;
  localparam int SEL_HI   = 6;
  localparam int SEL_LO   = 4;
  localparam int START_POS = 7;
  localparam int UNI_POS  = 3;
  localparam int SGL_POS  = 2;
  localparam int PIN_CS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_N    = 3;
  localparam int EDGE_N   = 2;

  typedef enum logic [1:0] {
    PWR_FULL_DOWN = 2'd0,
    PWR_FAST_DOWN = 2'd1,
    CLK_INTERNAL  = 2'd2,
    CLK_EXTERNAL  = 2'd3
  } pwrMode_e;

  typedef struct packed {
    logic firstBit;
    logic shiftIn;
    logic holdLoad;
    logic outShift;
    logic outClear;
  } ctrlStb_t;
endpackage

// File: rtl/adcfe_sync.sv
module adcfe_sync #(
  parameter int W = 3,
  parameter int EW = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  pinIn,
  output logic [W-1:0]  pinLvl,
  output logic [EW-1:0] pinPrv
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= {STAGES{RST_VAL[i]}};
      else       chain <= {chain[STAGES-2:0], pinIn[i]};
    end
    assign pinLvl[i] = chain[STAGES-1];
    if (i < EW) begin : g_edge
      logic prv;
      always_ff @(posedge clk) begin
        if (!rstN) prv <= RST_VAL[i];
        else       prv <= chain[STAGES-1];
      end
      assign pinPrv[i] = prv;
    end
  end
endmodule

// File: rtl/adcfe_ctrl.sv
module adcfe_ctrl
  import adcfe_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int TRACK_AFTER = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIN_N-1:0]  pinLvl,
  input  logic [EDGE_N-1:0] pinPrv,
  output ctrlStb_t          stb,
  output logic              sdoOe,
  output logic              trackOn,
  output logic              sampleStb,
  output logic              convActive
);
  localparam int CONV_FALLS    = RES_W + 2;
  localparam int RELEASE_FALLS = RES_W - 3;
  localparam int CNT_W         = $clog2(CONV_FALLS + 1);
  localparam int BIT_W         = $clog2(CTRL_W + 1);

  logic receiving, busy, abortArm;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] convCnt;
  logic csRise, csFall, rxEdge, txEdge;
  logic startOk, takeStart, holdNow, lastFall;

  always_comb begin
    csRise    = pinLvl[PIN_CS] & ~pinPrv[PIN_CS];
    csFall    = ~pinLvl[PIN_CS] & pinPrv[PIN_CS];
    rxEdge    = ~pinLvl[PIN_CS] & pinLvl[PIN_SCLK] & ~pinPrv[PIN_SCLK];
    txEdge    = ~pinLvl[PIN_CS] & ~pinLvl[PIN_SCLK] & pinPrv[PIN_SCLK];
    startOk   = !busy || (convCnt >= CNT_W'(RELEASE_FALLS)) || abortArm;
    takeStart = rxEdge && !receiving && pinLvl[PIN_SDI] && startOk;
    holdNow   = txEdge && receiving && (bitCnt == BIT_W'(CTRL_W));
    lastFall  = (convCnt == CNT_W'(CONV_FALLS - 1));
    stb.firstBit = takeStart;
    stb.shiftIn  = rxEdge && (receiving || takeStart);
    stb.holdLoad = holdNow;
    stb.outShift = txEdge && busy && !holdNow;
    stb.outClear = takeStart && busy && abortArm;
  end

  assign convActive = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      receiving <= 1'b0;
      busy      <= 1'b0;
      abortArm  <= 1'b0;
      bitCnt    <= '0;
      convCnt   <= '0;
      sdoOe     <= 1'b0;
      trackOn   <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      sampleStb <= holdNow;
      if (takeStart) begin
        receiving <= 1'b1;
        bitCnt    <= BIT_W'(1);
        if (busy && abortArm) begin
          busy     <= 1'b0;
          abortArm <= 1'b0;
          convCnt  <= '0;
        end
      end else if (rxEdge && receiving && bitCnt != BIT_W'(CTRL_W)) begin
        bitCnt <= bitCnt + BIT_W'(1);
      end
      if (txEdge && receiving && bitCnt == BIT_W'(TRACK_AFTER)) trackOn <= 1'b1;
      if (holdNow) begin
        trackOn   <= 1'b0;
        receiving <= 1'b0;
        bitCnt    <= '0;
        busy      <= 1'b1;
        convCnt   <= '0;
        abortArm  <= 1'b0;
      end else if (stb.outShift) begin
        convCnt <= convCnt + CNT_W'(1);
        if (lastFall) begin
          busy     <= 1'b0;
          abortArm <= 1'b0;
        end
      end
      if (csFall) sdoOe <= 1'b1;
      if (csRise) begin
        sdoOe     <= 1'b0;
        receiving <= 1'b0;
        bitCnt    <= '0;
        trackOn   <= 1'b0;
        if (busy) abortArm <= 1'b1;
      end
    end
  end

  // R6: a hold is always preceded by a track phase
  p_hold_after_track_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> $past(trackOn));
  // R6: a conversion only begins together with the hold strobe
  p_busy_with_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convActive) |-> sampleStb);
  // R6: tracking only happens inside a byte being received
  p_track_in_byte_r6: assert property (@(posedge clk) disable iff (!rstN)
    trackOn |-> receiving);
  // R7: falling-edge count never runs past the conversion length
  p_conv_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    convCnt <= CNT_W'(CONV_FALLS));
  // R2: the bit counter never exceeds one control byte
  p_bit_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_W'(CTRL_W));
  // R8: a byte may begin during a conversion only once released or re-armed
  p_start_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(receiving) |->
      (!$past(busy) || $past(convCnt) >= CNT_W'(RELEASE_FALLS) || $past(abortArm)));
endmodule

// File: rtl/adcfe_datapath.sv
module adcfe_datapath
  import adcfe_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic             sdiLvl,
  input  logic [RES_W-1:0] resultWord,
  output logic             sdo,
  output logic [CH_W-1:0]  posCh,
  output logic [CH_W-1:0]  negCh,
  output logic             negIsCom,
  output logic             unipolar,
  output logic             singleEnded,
  output logic [1:0]       pwrMode
);
  logic [CTRL_W-1:0] inReg;
  logic [RES_W-1:0]  outReg;
  logic [2:0]        selCode;
  logic [CH_W-1:0]   posNext, pairNeg;
  pwrMode_e          pwrR;
  logic              byteOk;

  always_comb begin
    selCode = inReg[SEL_HI:SEL_LO];
    posNext = {selCode[1], selCode[0], selCode[2]};
    pairNeg = {selCode[1], selCode[0], ~selCode[2]};
    byteOk  = inReg[START_POS];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg       <= '0;
      outReg      <= '0;
      sdo         <= 1'b0;
      posCh       <= '0;
      negCh       <= '0;
      negIsCom    <= 1'b1;
      unipolar    <= 1'b0;
      singleEnded <= 1'b1;
      pwrR        <= PWR_FULL_DOWN;
    end else begin
      if (stb.shiftIn) begin
        if (stb.firstBit) inReg <= CTRL_W'(1);
        else              inReg <= {inReg[CTRL_W-2:0], sdiLvl};
      end
      if (stb.holdLoad && byteOk) begin
        outReg      <= resultWord;
        sdo         <= 1'b0;
        posCh       <= posNext;
        unipolar    <= inReg[UNI_POS];
        singleEnded <= inReg[SGL_POS];
        pwrR        <= pwrMode_e'(inReg[1:0]);
        if (inReg[SGL_POS]) begin
          negIsCom <= 1'b1;
          negCh    <= '0;
        end else begin
          negIsCom <= 1'b0;
          negCh    <= pairNeg;
        end
      end else if (stb.outClear) begin
        outReg <= '0;
        sdo    <= 1'b0;
      end else if (stb.outShift) begin
        sdo    <= outReg[RES_W-1];
        outReg <= {outReg[RES_W-2:0], 1'b0};
      end
    end
  end

  assign pwrMode = pwrR;

  // R5: a differential selection always names the two members of one pair
  p_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    !negIsCom |-> (posCh[CH_W-1:1] == negCh[CH_W-1:1]) && (posCh[0] != negCh[0]));
  // R4: the common reference is used exactly in single-ended mode
  p_com_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    negIsCom == singleEnded);
endmodule

// File: rtl/adc_serial_frontend.sv
module adc_serial_frontend
  import adcfe_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int SYNC_STAGES = 2,
  parameter int TRACK_AFTER = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdi,
  input  logic [RES_W-1:0] resultWord,
  output logic             sdo,
  output logic             sdoOe,
  output logic [2:0]       posCh,
  output logic [2:0]       negCh,
  output logic             negIsCom,
  output logic             unipolar,
  output logic             singleEnded,
  output logic [1:0]       pwrMode,
  output logic             trackOn,
  output logic             sampleStb,
  output logic             convActive
);
  logic [PIN_N-1:0]  pinLvl;
  logic [EDGE_N-1:0] pinPrv;
  ctrlStb_t          stb;

  adcfe_sync #(.W(PIN_N), .EW(EDGE_N), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn({sdi, sclk, csN}), .pinLvl(pinLvl), .pinPrv(pinPrv));

  adcfe_ctrl #(.RES_W(RES_W), .TRACK_AFTER(TRACK_AFTER)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinLvl(pinLvl), .pinPrv(pinPrv), .stb(stb),
    .sdoOe(sdoOe), .trackOn(trackOn), .sampleStb(sampleStb), .convActive(convActive));

  adcfe_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiLvl(pinLvl[PIN_SDI]), .resultWord(resultWord),
    .sdo(sdo), .posCh(posCh), .negCh(negCh), .negIsCom(negIsCom), .unipolar(unipolar),
    .singleEnded(singleEnded), .pwrMode(pwrMode));
endmodule

// File: tb/adc_serial_frontend_test.sv
`timescale 1ns/1ps
module adc_serial_frontend_test;
  localparam int RES_W = 10;
  localparam int GAP = 5;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [RES_W-1:0] resultWord = '0;
  logic sdo, sdoOe, negIsCom, unipolar, singleEnded, trackOn, sampleStb, convActive;
  logic [2:0] posCh, negCh;
  logic [1:0] pwrMode;

  adc_serial_frontend #(.RES_W(RES_W)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .resultWord(resultWord),
    .sdo(sdo), .sdoOe(sdoOe), .posCh(posCh), .negCh(negCh), .negIsCom(negIsCom),
    .unipolar(unipolar), .singleEnded(singleEnded), .pwrMode(pwrMode), .trackOn(trackOn),
    .sampleStb(sampleStb), .convActive(convActive));

  always #2.5 clk = ~clk;

  int vectors = 0, misses = 0, settle = 0;
  bit checking = 0, done = 0;
  string curReq = "R12";

  // reference model state
  int seMap[8] = '{0, 2, 4, 6, 1, 3, 5, 7};
  bit mRx = 0, mBusy = 0, mAbort = 0, pend = 0;
  int mBits = 0, mFalls = 0;
  logic [7:0] mByte = '0;
  bit outQ[$];
  logic eSdo = 0, eOe = 0, eCom = 1, eUni = 0, eSgl = 1, eTrack = 0;
  logic [2:0] ePos = 0, eNeg = 0;
  logic [1:0] ePwr = 0;

  task automatic chk(string sig, string req, logic [9:0] act, logic [9:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s during %s: %s actual=%0h expected=%0h", req, curReq, sig, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && checking) begin
      if (settle > 1) settle--;
      else begin
        logic expS;
        expS = (settle == 1) ? pend : 1'b0;
        if (settle == 1) begin settle = 0; pend = 0; end
        chk("sdoOe", "R11", sdoOe, eOe);
        if (eOe) chk("sdo", "R7", sdo, eSdo);
        chk("posCh", eSgl ? "R4" : "R5", posCh, ePos);
        chk("negCh", eSgl ? "R4" : "R5", negCh, eNeg);
        chk("negIsCom", eSgl ? "R4" : "R5", negIsCom, eCom);
        chk("unipolar", "R3", unipolar, eUni);
        chk("singleEnded", "R3", singleEnded, eSgl);
        chk("pwrMode", "R3", pwrMode, ePwr);
        chk("trackOn", "R6", trackOn, eTrack);
        chk("sampleStb", "R6", sampleStb, expS);
        chk("convActive", "R6", convActive, mBusy);
      end
    end
  end

  task automatic model(bit oC, bit oS, bit nC, bit nS, bit nD);
    if (!oC && nC) begin
      mRx = 0; mBits = 0; eTrack = 0;
      if (mBusy) mAbort = 1;
    end
    eOe = !nC;
    if (!nC && !oS && nS) begin
      if (!mRx) begin
        if (nD && (!mBusy || mFalls >= RES_W - 3 || mAbort)) begin
          if (mBusy && mAbort) begin
            mBusy = 0; mAbort = 0; outQ.delete(); eSdo = 0;
          end
          mRx = 1; mBits = 1; mByte = 8'd1;
        end
      end else begin
        mByte = {mByte[6:0], nD};
        mBits++;
      end
    end
    if (!nC && oS && !nS) begin
      if (mRx && mBits == 5) eTrack = 1;
      if (mRx && mBits == 8) begin
        eTrack = 0; pend = 1; mRx = 0; mBits = 0;
        mBusy = 1; mFalls = 0; mAbort = 0; eSdo = 0;
        outQ.delete();
        for (int i = RES_W - 1; i >= 0; i--) outQ.push_back(resultWord[i]);
        eUni = mByte[3]; eSgl = mByte[2]; ePwr = mByte[1:0];
        if (eSgl) begin
          ePos = 3'(seMap[mByte[6:4]]); eNeg = 0; eCom = 1;
        end else begin
          int pr = mByte[5:4];
          eCom = 0;
          if (mByte[6]) begin ePos = 3'(2 * pr + 1); eNeg = 3'(2 * pr); end
          else          begin ePos = 3'(2 * pr);     eNeg = 3'(2 * pr + 1); end
        end
      end else if (mBusy) begin
        eSdo = (outQ.size() > 0) ? outQ.pop_front() : 1'b0;
        mFalls++;
        if (mFalls == RES_W + 2) begin mBusy = 0; mAbort = 0; end
      end
    end
  endtask

  task automatic drive(bit c, bit s, bit d);
    @(negedge clk);
    #1;
    model(csN, sclk, c, s, d);
    csN = c; sclk = s; sdi = d;
    settle = 3;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic pulse(bit d);
    drive(csN, 1'b0, d);
    drive(csN, 1'b1, d);
    drive(csN, 1'b0, d);
  endtask

  task automatic sendByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(b[i]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) pulse(1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    checking = 1;
    repeat (4) @(negedge clk);

    curReq = "R1";
    for (int i = 0; i < 8; i++) pulse(1'b1);

    curReq = "R2";
    drive(1'b0, 1'b0, 1'b0);
    idle(3);
    resultWord = 10'h2B5;
    sendByte(8'b1000_1111);
    curReq = "R7";
    idle(13);

    curReq = "R4";
    for (int s = 0; s < 8; s++) begin
      resultWord = 10'(37 * s + 5);
      sendByte({1'b1, 3'(s), 1'b1, 1'b1, 2'b10});
      idle(13);
    end

    curReq = "R5";
    for (int s = 0; s < 8; s++) begin
      resultWord = 10'(10'h3FF - 51 * s);
      sendByte({1'b1, 3'(s), 1'b0, 1'b0, 2'(s)});
      idle(13);
    end

    curReq = "R3";
    resultWord = 10'h155;
    sendByte(8'b1110_0101);
    idle(13);

    curReq = "R8";
    resultWord = 10'h3C3;
    sendByte(8'b1011_1111);
    idle(2);
    pulse(1'b1);
    idle(4);
    resultWord = 10'h0F0;
    sendByte(8'b1101_0110);
    idle(13);

    curReq = "R9";
    pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1); pulse(1'b1);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    idle(2);
    resultWord = 10'h2AA;
    sendByte(8'b1001_1011);
    idle(13);

    curReq = "R10";
    resultWord = 10'h1FF;
    sendByte(8'b1111_1111);
    idle(3);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    idle(2);
    resultWord = 10'h301;
    sendByte(8'b1010_0010);
    idle(13);

    curReq = "R11";
    drive(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) pulse(1'b1);
    drive(1'b0, 1'b0, 1'b0);
    repeat (8) @(negedge clk);

    checking = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog during %s: actual=hung expected=finished", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule